// File: doc/BRIEF.md
# Fuse Programming Register Front End

This block sits between a simple memory-mapped register bus and the engines of a one-time-programmable fuse controller. Software reaches a control word (with separate bit-set and bit-clear views), a timing word and a program-data word through it. The block holds the target fuse-word address, checks a per-access unlock key, and keeps the busy and error status. When the data word is written while a program operation is armed, it starts the serial burn engine. A shadow reload started from the control word starts the reload engine instead.

A program operation takes a snapshot of the address at launch, so later address writes cannot redirect a burn in flight. The data word is frozen until the engine reports completion. A per-word lock bitmap turns a program request into an error, and no fuse access takes place. Overlapping requests are refused and also raise the error flag. The error flag stays set and blocks every new command until software clears it through the bit-clear view.

Top module: `otp_regfront`

## Requirements
- R1: Byte offsets: 0x00 control, 0x04 control bit-set view, 0x08 control bit-clear view, 0x10 timing, 0x20 program data; reads of all three control offsets return the control word, and other offsets read zero. After reset every register reads zero.
- R2: Control word layout: bits [7:0] word address, bit 8 busy, bit 9 error, bit 10 shadow reload in progress, bits [31:16] read 0x3E77 while the unlock is armed and zero otherwise. A write to 0x00 loads the address, a write to 0x04 ORs wdata[7:0] into it, and a write to 0x08 clears the address bits that are set in wdata[7:0].
- R3: A write to 0x00 arms the unlock when wdata[31:16] equals 0x3E77 and disarms it for any other value. The address and the key may share one access.
- R4: A data write while idle, error-free and armed, to an unlocked word, sets busy, drives prog_start high for the one cycle after the write, presents the data on prog_data and disarms the unlock. A data write without the unlock only stores the data.
- R5: prog_addr takes the address at launch and holds it while busy, whatever is written to the address field.
- R6: While busy, a data write leaves the data word unchanged and sets error.
- R7: A program request to a word whose wlock_map bit is 1, or whose address is at or above NUM_WORDS, does not start, leaves busy clear, sets error and still consumes the unlock.
- R8: While error is set, no program or reload starts. Only writing 1 to bit 9 at 0x08 clears error; writing bit 9 at 0x00 has no effect.
- R9: Writing 1 to bit 10 at 0x00 or 0x04 while idle and error-free sets busy and bit 10 and pulses reload_start for one cycle. reload_done clears both.
- R10: prog_done ends only a program operation and reload_done ends only a reload. A reload request while busy does not start and sets error.
- R11: The timing word is a 32-bit read/write register whose value drives timing_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wlock_map | input | NUM_WORDS | Per-word program lock, 1 = locked |
| prog_start | output | 1 | One-cycle burn launch pulse |
| prog_addr | output | 8 | Address snapshot for the burn |
| prog_data | output | 32 | Word to burn |
| prog_done | input | 1 | Burn engine finished |
| reload_start | output | 1 | One-cycle shadow reload launch pulse |
| reload_done | input | 1 | Reload engine finished |
| timing_cfg | output | 32 | Timing word for the engines |

## Verification
Read data is combinational, so a read is sampled one nanosecond after the address is applied, with no clock edge in between. Every write result (address, unlock, busy, error, the launch pulses and the prog_addr snapshot) is due on the first rising edge after the write. The bench drives each access on a falling edge and checks at the next falling edge, which is inside the single cycle in which a launch pulse is high. All 256 word addresses are swept with a computed lock pattern. On each unlocked word the bench checks the address snapshot against a competing address write and a refused data write, and it ends the operation with a completion pulse.

// File: rtl/otp_regfront_pkg.sv
package otp_regfront_pkg;
  localparam logic [7:0]  OFS_CTRL   = 8'h00;
  localparam logic [7:0]  OFS_SET    = 8'h04;
  localparam logic [7:0]  OFS_CLR    = 8'h08;
  localparam logic [7:0]  OFS_TIME   = 8'h10;
  localparam logic [7:0]  OFS_DATA   = 8'h20;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int          WADDR_W    = 8;
  localparam int          BIT_ERR    = 9;
  localparam int          BIT_RELOAD = 10;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_RELOAD = 2'd2
  } op_e;

  typedef struct packed {
    logic ctrl_wr;
    logic set_wr;
    logic clr_wr;
    logic time_wr;
    logic data_wr;
  } wr_strobe_t;
endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
  import otp_regfront_pkg::*;
(
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  output wr_strobe_t strb
);
  always_comb begin
    strb = '0;
    if (bus_sel && bus_wr) begin
      case (bus_addr)
        OFS_CTRL: strb.ctrl_wr = 1'b1;
        OFS_SET:  strb.set_wr  = 1'b1;
        OFS_CLR:  strb.clr_wr  = 1'b1;
        OFS_TIME: strb.time_wr = 1'b1;
        OFS_DATA: strb.data_wr = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/otp_ctrl_state.sv
module otp_ctrl_state
  import otp_regfront_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  wr_strobe_t         strb,
  input  logic [15:0]        wkey,
  input  logic [WADDR_W-1:0] waddr,
  input  logic               wreq_reload,
  input  logic               wclr_err,
  input  logic               word_locked,
  input  logic               prog_done,
  input  logic               reload_done,
  output logic [WADDR_W-1:0] addr_q,
  output logic               unlock_q,
  output logic               busy,
  output logic               error_q,
  output logic               reload_q,
  output logic               data_we,
  output logic               prog_start,
  output logic               reload_start,
  output logic [WADDR_W-1:0] prog_addr
);
  op_e                op_q, op_d;
  logic [WADDR_W-1:0] addr_d;
  logic               unlock_d, error_d, pstart_d, rstart_d;
  logic               reload_req, prog_req;

  assign busy     = (op_q != OP_IDLE);
  assign reload_q = (op_q == OP_RELOAD);
  assign data_we  = strb.data_wr && (op_q == OP_IDLE);

  always_comb begin
    addr_d = addr_q;
    if (strb.ctrl_wr)     addr_d = waddr;
    else if (strb.set_wr) addr_d = addr_q | waddr;
    else if (strb.clr_wr) addr_d = addr_q & ~waddr;

    unlock_d = unlock_q;
    if (strb.ctrl_wr)      unlock_d = (wkey == UNLOCK_KEY);
    else if (strb.data_wr) unlock_d = 1'b0;

    reload_req = (strb.ctrl_wr || strb.set_wr) && wreq_reload;
    prog_req   = strb.data_wr && unlock_q;

    op_d     = op_q;
    error_d  = error_q;
    pstart_d = 1'b0;
    rstart_d = 1'b0;
    if (strb.clr_wr && wclr_err) error_d = 1'b0;

    if (op_q != OP_IDLE) begin
      if (strb.data_wr || reload_req) error_d = 1'b1;
      if ((op_q == OP_PROG && prog_done) || (op_q == OP_RELOAD && reload_done))
        op_d = OP_IDLE;
    end else if (!error_q) begin
      if (prog_req) begin
        if (word_locked) begin
          error_d = 1'b1;
        end else begin
          op_d     = OP_PROG;
          pstart_d = 1'b1;
        end
      end else if (reload_req) begin
        op_d     = OP_RELOAD;
        rstart_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q         <= OP_IDLE;
      addr_q       <= '0;
      unlock_q     <= 1'b0;
      error_q      <= 1'b0;
      prog_start   <= 1'b0;
      reload_start <= 1'b0;
      prog_addr    <= '0;
    end else begin
      op_q         <= op_d;
      addr_q       <= addr_d;
      unlock_q     <= unlock_d;
      error_q      <= error_d;
      prog_start   <= pstart_d;
      reload_start <= rstart_d;
      if (pstart_d) prog_addr <= addr_q;
    end
  end
endmodule

// File: rtl/otp_regfront.sv
module otp_regfront
  import otp_regfront_pkg::*;
#(
  parameter int NUM_WORDS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_WORDS-1:0] wlock_map,
  output logic                 prog_start,
  output logic [WADDR_W-1:0]   prog_addr,
  output logic [31:0]          prog_data,
  input  logic                 prog_done,
  output logic                 reload_start,
  input  logic                 reload_done,
  output logic [31:0]          timing_cfg
);
  localparam int WA_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [WADDR_W:0] WORDS_LIM = (WADDR_W + 1)'(NUM_WORDS);

  wr_strobe_t         strb;
  logic [WADDR_W-1:0] addr_q;
  logic               unlock_armed, busy, error_flag, reload_q, data_we, word_locked;
  logic [31:0]        data_q, timing_q, ctrl_word;

  otp_bus_decode u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .strb    (strb)
  );

  generate
    if (NUM_WORDS >= (1 << WADDR_W)) begin : g_full_map
      assign word_locked = wlock_map[addr_q];
    end else begin : g_part_map
      assign word_locked = ({1'b0, addr_q} >= WORDS_LIM) || wlock_map[addr_q[WA_W-1:0]];
    end
  endgenerate

  otp_ctrl_state u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .wkey        (bus_wdata[31:16]),
    .waddr       (bus_wdata[WADDR_W-1:0]),
    .wreq_reload (bus_wdata[BIT_RELOAD]),
    .wclr_err    (bus_wdata[BIT_ERR]),
    .word_locked (word_locked),
    .prog_done   (prog_done),
    .reload_done (reload_done),
    .addr_q      (addr_q),
    .unlock_q    (unlock_armed),
    .busy        (busy),
    .error_q     (error_flag),
    .reload_q    (reload_q),
    .data_we     (data_we),
    .prog_start  (prog_start),
    .reload_start(reload_start),
    .prog_addr   (prog_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      timing_q <= '0;
    end else begin
      if (data_we)      data_q   <= bus_wdata;
      if (strb.time_wr) timing_q <= bus_wdata;
    end
  end

  assign prog_data  = data_q;
  assign timing_cfg = timing_q;
  assign ctrl_word  = {unlock_armed ? UNLOCK_KEY : 16'h0000, 5'b0,
                       reload_q, error_flag, busy, addr_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        OFS_CTRL, OFS_SET, OFS_CLR: bus_rdata = ctrl_word;
        OFS_TIME:                   bus_rdata = timing_q;
        OFS_DATA:                   bus_rdata = data_q;
        default:                    ;
      endcase
    end
  end
endmodule

// File: rtl/otp_regfront_chk.sv
module otp_regfront_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       error_flag,
  input logic       unlock_armed,
  input logic       prog_start,
  input logic       reload_start,
  input logic [7:0] prog_addr,
  input logic [31:0] data_q
);
  assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);
  assert_key_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !unlock_armed);
  assert_prog_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(prog_addr));
  assert_data_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q));
  assert_error_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    error_flag |=> (!prog_start && !reload_start));
  assert_single_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !reload_start);
  assert_launch_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || reload_start) |-> !$past(busy));
endmodule

bind otp_regfront otp_regfront_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .error_flag  (error_flag),
  .unlock_armed(unlock_armed),
  .prog_start  (prog_start),
  .reload_start(reload_start),
  .prog_addr   (prog_addr),
  .data_q      (data_q)
);

// File: tb/otp_regfront_bench.sv
`timescale 1ns/1ps
module otp_regfront_bench;
  localparam int NW = 256;
  localparam logic [7:0] A_CTRL = 8'h00, A_SET = 8'h04, A_CLR = 8'h08,
                         A_TIME = 8'h10, A_DATA = 8'h20;
  localparam logic [15:0] KEY = 16'h3E77;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, bus_sel, bus_wr, prog_done, reload_done;
  logic [7:0]    bus_addr, prog_addr;
  logic [31:0]   bus_wdata, bus_rdata, prog_data, timing_cfg;
  logic [NW-1:0] wlock_map;
  logic          prog_start, reload_start;
  int checks = 0, failures = 0;

  otp_regfront u_otp_regfront (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wlock_map(wlock_map), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_done(prog_done), .reload_start(reload_start),
    .reload_done(reload_done), .timing_cfg(timing_cfg)
  );

  function automatic logic is_locked(input int a);
    return (a % 5) == 2;
  endfunction

  function automatic logic [31:0] cw(input logic key, rel, err, bsy, input logic [7:0] a);
    return {key ? KEY : 16'h0000, 5'b0, rel, err, bsy, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse_prog_done;
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic pulse_reload_done;
    @(negedge clk); reload_done = 1'b1;
    @(negedge clk); reload_done = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    prog_done = 1'b0; reload_done = 1'b0;
    for (int i = 0; i < NW; i++) wlock_map[i] = is_locked(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and map
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    rd(A_TIME, v); chk("R1 timing reset", v, 32'h0);
    rd(A_DATA, v); chk("R1 data reset", v, 32'h0);
    chk("R1 no launch at reset", {31'b0, prog_start | reload_start}, 32'h0);

    // R11 timing word
    bw(A_TIME, 32'h0012_3456);
    rd(A_TIME, v); chk("R11 timing readback", v, 32'h0012_3456);
    chk("R11 timing_cfg", timing_cfg, 32'h0012_3456);
    rd(8'h30, v); chk("R1 unmapped reads zero", v, 32'h0);

    // R2 address field and aliases
    bw(A_CTRL, 32'h0000_005A);
    rd(A_CTRL, v); chk("R2 plain address write", v, cw(0,0,0,0,8'h5A));
    bw(A_SET, 32'h0000_0081);
    rd(A_SET, v); chk("R2 set alias", v, cw(0,0,0,0,8'hDB));
    bw(A_CLR, 32'h0000_000F);
    rd(A_CLR, v); chk("R2 clear alias", v, cw(0,0,0,0,8'hD0));

    // R3 arming
    bw(A_CTRL, {KEY, 16'h0011});
    rd(A_CTRL, v); chk("R3 key arms with address", v, cw(1,0,0,0,8'h11));
    bw(A_CTRL, 32'h1234_0011);
    rd(A_CTRL, v); chk("R3 wrong key disarms", v, cw(0,0,0,0,8'h11));

    // R4 data write without unlock only stores
    bw(A_DATA, 32'hCAFE_F00D);
    chk("R4 no launch without key", {31'b0, prog_start}, 32'h0);
    rd(A_DATA, v); chk("R4 data stored", v, 32'hCAFE_F00D);
    rd(A_CTRL, v); chk("R4 not busy", v, cw(0,0,0,0,8'h11));

    // Sweep of every word address (R4 R5 R6 R7 R10)
    for (int a = 0; a < NW; a++) begin
      d = {a[7:0], ~a[7:0], a[7:0] ^ 8'h3C, 8'h5A};
      bw(A_CTRL, {KEY, 8'h00, a[7:0]});
      bw(A_DATA, d);
      if (is_locked(a)) begin
        chk("R7 locked word no launch", {31'b0, prog_start}, 32'h0);
        rd(A_CTRL, v); chk("R7 locked word error", v, cw(0,0,1,0,a[7:0]));
        bw(A_CLR, 32'h0000_0200);
        rd(A_CTRL, v); chk("R8 error cleared", v, cw(0,0,0,0,a[7:0]));
      end else begin
        chk("R4 launch pulse", {31'b0, prog_start}, 32'h1);
        chk("R5 snapshot address", {24'b0, prog_addr}, {24'b0, a[7:0]});
        chk("R4 prog data", prog_data, d);
        rd(A_CTRL, v); chk("R4 busy set key consumed", v, cw(0,0,0,1,a[7:0]));
        bw(A_CTRL, {24'b0, ~a[7:0]});
        chk("R4 pulse one cycle", {31'b0, prog_start}, 32'h0);
        chk("R5 address held", {24'b0, prog_addr}, {24'b0, a[7:0]});
        if (a % 16 == 1) begin
          bw(A_DATA, 32'hDEAD_0000);
          chk("R6 data frozen", prog_data, d);
        end
        pulse_prog_done();
        rd(A_CTRL, v);
        chk("R10 done clears busy", v, cw(0,0,(a % 16 == 1),0,~a[7:0]));
        if (a % 16 == 1) bw(A_CLR, 32'h0000_0200);
      end
    end

    // R8 error blocks commands
    bw(A_CTRL, {KEY, 16'h0002});
    bw(A_DATA, 32'h1);
    bw(A_CTRL, {KEY, 16'h0003});
    bw(A_DATA, 32'h5);
    chk("R8 program blocked", {31'b0, prog_start}, 32'h0);
    rd(A_CTRL, v); chk("R8 status while blocked", v, cw(0,0,1,0,8'h03));
    bw(A_SET, 32'h0000_0400);
    chk("R8 reload blocked", {31'b0, reload_start}, 32'h0);
    bw(A_CTRL, 32'h0000_0203);
    rd(A_CTRL, v); chk("R8 plain write keeps error", v, cw(0,0,1,0,8'h03));
    bw(A_CLR, 32'h0000_0200);
    rd(A_CTRL, v); chk("R8 cleared", v, cw(0,0,0,0,8'h03));
    bw(A_CTRL, {KEY, 16'h0003});
    bw(A_DATA, 32'h7);
    chk("R8 launch after clear", {31'b0, prog_start}, 32'h1);
    pulse_prog_done();

    // R9 R10 reload
    bw(A_SET, 32'h0000_0400);
    chk("R9 reload pulse", {31'b0, reload_start}, 32'h1);
    rd(A_CTRL, v); chk("R9 reload busy", v, cw(0,1,0,1,8'h03));
    pulse_prog_done();
    rd(A_CTRL, v); chk("R10 wrong done ignored", v, cw(0,1,0,1,8'h03));
    bw(A_SET, 32'h0000_0400);
    chk("R10 overlap no pulse", {31'b0, reload_start}, 32'h0);
    rd(A_CTRL, v); chk("R10 overlap error", v, cw(0,1,1,1,8'h03));
    pulse_reload_done();
    rd(A_CTRL, v); chk("R9 reload done", v, cw(0,0,1,0,8'h03));
    bw(A_CLR, 32'h0000_0200);
    bw(A_CTRL, 32'h0000_0407);
    chk("R9 reload via plain write", {31'b0, reload_start}, 32'h1);
    rd(A_CTRL, v); chk("R9 plain reload status", v, cw(0,1,0,1,8'h07));
    pulse_reload_done();
    rd(A_CTRL, v); chk("R9 idle again", v, cw(0,0,0,0,8'h07));

    summary();
  end
endmodule